// File: doc/BRIEF.md
# Serial Readback Trigger Controller

This block streams a stored bit image out on one serial pin when asked. The image might be a configuration store with captured flip-flop state mixed in. A request arrives as a rising edge on an asynchronous trigger input. The block synchronizes that edge into the readout clock domain. It then walks a bit address from zero up to the last bit of a fixed-length frame and presents one image bit per rising edge of the readout clock. A busy output stays high for the whole transfer, so an external tester knows when the stream is valid.

Three setup inputs shape the behaviour. The first is a master enable, without which no transfer ever starts. The second is an abort enable, which lets a falling trigger cut a transfer short. The third selects the clock source: either a user-supplied readout clock, or an internal configuration clock that is used only when it is selected and no user clock is declared present. The image is read through a synchronous one-bit port. The block drives the address, and the returned bit is captured at the next rising edge of the readout clock.

Top module: `rb_readback_ctrl`

## Requirements
- R1: A transfer starts only on a low-to-high change of `trigIn`. Holding `trigIn` high after a frame has ended never starts another frame.
- R2: After `trigIn` rises, `rbBusy` goes high at the third rising edge of the readout clock: two synchronizer stages, then the edge detector. `rbData` is still 0 at that point.
- R3: Bits leave in address order, 0 first and `FRAME_LEN-1` last. The bit for address i appears on `rbData` at the (i+1)-th readout edge after `rbBusy` rises. `memAddr` stays at `FRAME_LEN-1` once it reaches it and never exceeds it.
- R4: `rbBusy` stays high until one readout edge after the last bit was presented. At that edge `rbBusy` drops and `rbData` returns to 0.
- R5: While `rbEnable` is low, a trigger rising edge starts nothing and `rbBusy` stays low.
- R6: With `abortEn` high, a falling `trigIn` during a transfer ends it at the third readout edge after the fall. At that edge `rbBusy` and `rbData` go to 0, and the bits presented before that edge still follow R3.
- R7: With `abortEn` low, a falling `trigIn` during a transfer has no effect and the full frame is sent.
- R8: A rising `trigIn` edge during a transfer is ignored. The frame neither restarts nor changes its bit order.
- R9: After an abort, the next rising trigger edge starts a fresh frame, with `memAddr` back at 0 and address 0 sent first.
- R10: The readout clock is `cfgClk` only when `selInternalClk` is high and `usrClkPresent` is low. Otherwise it is `usrClk`.
- R11: While `rstN` is low, `rbBusy`, `rbData` and `memAddr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| usrClk | input | 1 | User-supplied readout clock |
| cfgClk | input | 1 | Internal configuration clock |
| rstN | input | 1 | Asynchronous active-low reset |
| usrClkPresent | input | 1 | Setting: a user readout clock is connected |
| selInternalClk | input | 1 | Setting: prefer the internal configuration clock |
| rbEnable | input | 1 | Setting: master enable for readback |
| abortEn | input | 1 | Setting: a falling trigger may abort a transfer |
| trigIn | input | 1 | Asynchronous readback trigger |
| memAddr | output | $clog2(FRAME_LEN) | Bit address into the stored image |
| memBit | input | 1 | Image bit at `memAddr`, captured at the next readout edge |
| rbData | output | 1 | Serial readback data |
| rbBusy | output | 1 | A transfer is in progress |

## Verification
On every readout edge the assertions check the following: the address bound and the step-by-one address walk, that a transfer begins only on a synchronized rise with the enable set, that abort is taken or ignored according to `abortEn`, that a rise mid-frame leaves the shift state untouched, and that data is 0 once busy falls. Other properties depend on the actual bit values and the edge-by-edge timing seen at the pins, so only the bench scenarios can show them. These are the three-edge start latency, the exact bit sequence against the image, the bits still emitted between a fall and the abort it causes, the restart from address 0, the held-high trigger that never retriggers, and which of the two clocks actually moves the stream.

// File: rtl/rb_pkg.sv
package rb_pkg;

  // Strobes from control to datapath, at most one high per edge
  typedef struct packed {
    logic load;   // zero the address, start of a frame
    logic shift;  // capture the image bit, advance the address
    logic clear;  // force serial data to its idle level
  } rbStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2
  } rbState_e;

endpackage

// File: rtl/rb_clk_sel.sv
module rb_clk_sel (
  input  logic usrClk,
  input  logic cfgClk,
  input  logic usrClkPresent,
  input  logic selInternalClk,
  output logic rbClk
);

  logic useCfg;

  // The internal clock wins only when it is asked for and nothing external exists
  assign useCfg = selInternalClk & ~usrClkPresent;
  assign rbClk  = useCfg ? cfgClk : usrClk;

endmodule

// File: rtl/rb_trig_sync.sv
module rb_trig_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic trigIn,
  output logic trigRise,
  output logic trigFall
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] syncQ;
  logic         prevQ;

  genvar g;
  generate
    for (g = 0; g <= TOP; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= trigIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[TOP];
  end

  assign trigRise = syncQ[TOP] & ~prevQ;
  assign trigFall = ~syncQ[TOP] & prevQ;

endmodule

// File: rtl/rb_ctrl.sv
module rb_ctrl
  import rb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rbEnable,
  input  logic      abortEn,
  input  logic      trigRise,
  input  logic      trigFall,
  input  logic      atLast,
  output rbStrobe_t strobe,
  output logic      busy
);

  rbState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (trigRise && rbEnable) begin
          strobe.load = 1'b1;
          stateD      = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (trigFall && abortEn) begin
          strobe.clear = 1'b1;
          stateD       = ST_IDLE;
        end else begin
          strobe.shift = 1'b1;
          if (atLast) stateD = ST_TAIL;
        end
      end
      ST_TAIL: begin
        strobe.clear = 1'b1;
        stateD       = ST_IDLE;
      end
      default: begin
        strobe.clear = 1'b1;
        stateD       = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ != ST_IDLE);

  // R1
  start_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(trigRise));

  // R5
  start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(rbEnable));

  // R6
  abort_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && trigFall && abortEn) |=> !busy);

  // R7
  abort_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SHIFT && !atLast && trigFall && !abortEn) |=> stateQ == ST_SHIFT);

  // R8
  rise_mid_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SHIFT && !atLast && trigRise) |=> stateQ == ST_SHIFT);

endmodule

// File: rtl/rb_datapath.sv
module rb_datapath
  import rb_pkg::*;
#(
  parameter int FRAME_LEN = 24,
  parameter int ADDR_W    = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rbStrobe_t         strobe,
  input  logic              memBit,
  output logic [ADDR_W-1:0] memAddr,
  output logic              rbData,
  output logic              atLast
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(FRAME_LEN - 1);

  logic [ADDR_W-1:0] addrQ;
  logic              dataQ;

  assign atLast = (addrQ == LAST_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (strobe.load) begin
      addrQ <= '0;
    end else if (strobe.shift && !atLast) begin
      addrQ <= addrQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= 1'b0;
    end else if (strobe.clear) begin
      dataQ <= 1'b0;
    end else if (strobe.shift) begin
      dataQ <= memBit;
    end
  end

  assign memAddr = addrQ;
  assign rbData  = dataQ;

  // R3
  addr_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrQ <= LAST_ADDR);

  // R3
  addr_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shift && !atLast && !strobe.load) |=> addrQ == $past(addrQ) + 1'b1);

  // R9
  addr_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> addrQ == '0);

endmodule

// File: rtl/rb_readback_ctrl.sv
module rb_readback_ctrl
  import rb_pkg::*;
#(
  parameter int FRAME_LEN   = 24,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
  input  logic              usrClk,
  input  logic              cfgClk,
  input  logic              rstN,
  input  logic              usrClkPresent,
  input  logic              selInternalClk,
  input  logic              rbEnable,
  input  logic              abortEn,
  input  logic              trigIn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memBit,
  output logic              rbData,
  output logic              rbBusy
);

  logic      rbClk;
  logic      trigRise;
  logic      trigFall;
  logic      atLast;
  rbStrobe_t strobe;

  rb_clk_sel u_clk_sel (
    .usrClk         (usrClk),
    .cfgClk         (cfgClk),
    .usrClkPresent  (usrClkPresent),
    .selInternalClk (selInternalClk),
    .rbClk          (rbClk)
  );

  rb_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_trig_sync (
    .clk      (rbClk),
    .rstN     (rstN),
    .trigIn   (trigIn),
    .trigRise (trigRise),
    .trigFall (trigFall)
  );

  rb_ctrl u_ctrl (
    .clk      (rbClk),
    .rstN     (rstN),
    .rbEnable (rbEnable),
    .abortEn  (abortEn),
    .trigRise (trigRise),
    .trigFall (trigFall),
    .atLast   (atLast),
    .strobe   (strobe),
    .busy     (rbBusy)
  );

  rb_datapath #(.FRAME_LEN(FRAME_LEN), .ADDR_W(ADDR_W)) u_datapath (
    .clk     (rbClk),
    .rstN    (rstN),
    .strobe  (strobe),
    .memBit  (memBit),
    .memAddr (memAddr),
    .rbData  (rbData),
    .atLast  (atLast)
  );

  // R4
  idle_data_low_chk: assert property (@(posedge rbClk) disable iff (!rstN)
    $fell(rbBusy) |-> !rbData);

endmodule

// File: tb/rb_readback_ctrl_tb.sv
`timescale 1ns/1ps
module rb_readback_ctrl_tb;

  localparam int LEN    = 20;
  localparam int ADDR_W = $clog2(LEN);

  logic clk = 1'b0;
  logic usrRun = 1'b1, cfgRun = 1'b0;
  logic rstN = 1'b0;
  logic usrClkPresent = 1'b1, selInternalClk = 1'b0;
  logic rbEnable = 1'b1, abortEn = 1'b0, trigIn = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic memBit, rbData, rbBusy;
  int   pat = 0;
  int   total = 0, fails = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  wire usrClk = clk & usrRun;
  wire cfgClk = clk & cfgRun;

  function automatic logic memFn(int a, int p);
    int v;
    v = (a * 7 + p) ^ (a >> 2) ^ (p >> 3);
    return v[0];
  endfunction

  assign memBit = memFn(int'(memAddr), pat);

  rb_readback_ctrl #(.FRAME_LEN(LEN)) u_dut (
    .usrClk(usrClk), .cfgClk(cfgClk), .rstN(rstN),
    .usrClkPresent(usrClkPresent), .selInternalClk(selInternalClk),
    .rbEnable(rbEnable), .abortEn(abortEn), .trigIn(trigIn),
    .memAddr(memAddr), .memBit(memBit), .rbData(rbData), .rbBusy(rbBusy)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // mode: 0 plain, 1 trigger falls after bit k, 2 low pulse after bit k
  task automatic runFrame(int mode, int k);
    bit aborted = 1'b0;
    trigIn = 1'b1;
    cyc(2);
    chk(rbBusy == 1'b0, "R2 early", int'(rbBusy), 0);
    cyc(1);
    chk(rbBusy == 1'b1, "R2 busy", int'(rbBusy), 1);
    chk(rbData == 1'b0, "R2 data", int'(rbData), 0);
    chk(memAddr == '0, "R9 addr", int'(memAddr), 0);
    for (int i = 0; i < LEN; i++) begin
      cyc(1);
      if (abortEn && mode != 0 && i == k + 3) begin
        chk(rbBusy == 1'b0, "R6 busy", int'(rbBusy), 0);
        chk(rbData == 1'b0, "R6 data", int'(rbData), 0);
        aborted = 1'b1;
        break;
      end
      chk(rbData == memFn(i, pat), "R3 bit", int'(rbData), int'(memFn(i, pat)));
      chk(rbBusy == 1'b1, "R4 busy", int'(rbBusy), 1);
      chk(int'(memAddr) == ((i + 1 < LEN) ? i + 1 : LEN - 1), "R3 addr",
          int'(memAddr), (i + 1 < LEN) ? i + 1 : LEN - 1);
      if (mode != 0 && i == k) trigIn = 1'b0;
      if (mode == 2 && !abortEn && i == k + 1) trigIn = 1'b1;
    end
    if (!aborted) begin
      cyc(1);
      chk(rbBusy == 1'b0, "R4 end", int'(rbBusy), 0);
      chk(rbData == 1'b0, "R4 data", int'(rbData), 0);
      for (int j = 0; j < 4; j++) begin
        cyc(1);
        chk(rbBusy == 1'b0, "R1 held", int'(rbBusy), 0);
      end
    end
    trigIn = 1'b0;
    cyc(4);
  endtask

  initial begin
    cyc(2);
    // R11
    chk(rbBusy == 1'b0, "R11 busy", int'(rbBusy), 0);
    chk(rbData == 1'b0, "R11 data", int'(rbData), 0);
    chk(memAddr == '0, "R11 addr", int'(memAddr), 0);
    rstN = 1'b1;
    cyc(2);

    // directed full frame, trigger held high afterwards (R1-R4)
    pat = 5;
    runFrame(0, 0);

    // R5 enable low
    rbEnable = 1'b0;
    trigIn = 1'b1;
    for (int j = 0; j < 6; j++) begin
      cyc(1);
      chk(rbBusy == 1'b0, "R5", int'(rbBusy), 0);
    end
    trigIn = 1'b0;
    cyc(4);
    rbEnable = 1'b1;

    // directed abort at bit 0 then restart (R6, R9)
    abortEn = 1'b1;
    runFrame(1, 0);
    runFrame(0, 0);
    // R7 fall ignored, R8 rise ignored
    abortEn = 1'b0;
    runFrame(1, LEN - 4);
    runFrame(2, 2);

    // random mix with fixed seed
    void'($urandom(32'h5eed));
    for (int n = 0; n < 12; n++) begin
      pat     = int'($urandom % 1000);
      abortEn = $urandom % 2;
      runFrame(int'($urandom % 3), int'($urandom % (LEN - 3)));
    end

    // R10 internal clock chosen, user clock stopped
    abortEn = 1'b0;
    usrRun = 1'b0; cfgRun = 1'b1;
    selInternalClk = 1'b1; usrClkPresent = 1'b0;
    cyc(2);
    runFrame(0, 0);
    // R10 user clock declared present: internal clock must not drive readout
    usrClkPresent = 1'b1;
    trigIn = 1'b1;
    for (int j = 0; j < 6; j++) begin
      cyc(1);
      chk(rbBusy == 1'b0, "R10 user sel", int'(rbBusy), 0);
    end
    trigIn = 1'b0;
    usrRun = 1'b1; cfgRun = 1'b0;
    cyc(4);
    runFrame(0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule